// File: doc/BRIEF.md
# Bus Selection Response Qualifier

This block decides, for a target on a parallel SCSI-style bus, whether a selection or reselection started by another device should be answered. In the cycle marked by `selValid` it samples the ID lines and the per-byte parity bits. It then checks them against the local device ID and against three configuration inputs. `parityEn` turns parity checking on. `wideSys` declares that every device on the bus is 16 bits wide. `disSingleInit` rejects the legacy form of selection in which only the target's own ID line is driven.

The result appears one clock later as three registered outputs: a one-cycle accept strobe, the binary ID of the initiator, and a one-cycle parity-error pulse. With `disSingleInit` set, a single flipped data line cannot pass as a valid selection. With `wideSys` set, upper-byte parity is always checked, so a narrow initiator that never drives that parity bit is turned away. The block handles one selection event at a time. Arbitration, phase control and the bus handshake are left to the surrounding logic.

Top module: `sel_qualifier`

## Requirements
- R1: While `rstN` is low, and on the first clock after it rises with no event, `acceptStb`, `parityErr` and `initiatorId` are all zero.
- R2: Results are registered. They appear in the cycle after the edge that samples `selValid` high, and they last exactly one cycle. With `selValid` low all three outputs are zero.
- R3: With `wideSys` low, only `idBus[7:0]` and `idPar[0]` take part in the decision. Any value on `idBus[15:8]` or `idPar[1]` has no effect on the outputs.
- R4: A selection is accepted only if the line whose index equals `localId` is asserted among the considered lines. In narrow mode a `localId` of 8 or above never matches.
- R5: When exactly two considered lines are asserted, and one of them is the local line, the selection is accepted (subject to R10). `initiatorId` then carries the binary index of the other line.
- R6: When the local line is the only asserted line, the selection is accepted with `initiatorId` = 0 if `disSingleInit` is low. It is ignored if `disSingleInit` is high.
- R7: A selection with no considered line asserted, or with more than two asserted, is always rejected.
- R8: Parity is odd per byte. Byte 0 is `idBus[7:0]` with `idPar[0]`, and byte 1 is `idBus[15:8]` with `idPar[1]`. The XOR of a byte and its parity bit must be 1. With `parityEn` low no byte is checked. With `parityEn` high, byte 0 is always checked.
- R9: With `wideSys` and `parityEn` both high, byte 1 parity is always checked. A narrow initiator that leaves `idBus[15:8]` and `idPar[1]` low therefore fails and is not accepted.
- R10: When any checked byte fails parity, `parityErr` pulses for one cycle and `acceptStb` stays low, whatever the ID lines hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| selValid | input | 1 | Selection event: sample the ID lines this cycle |
| idBus | input | 16 | Bus ID lines, one per device ID |
| idPar | input | 2 | Odd parity per byte of `idBus` |
| localId | input | 4 | This device's ID |
| disSingleInit | input | 1 | Reject selections where only the local line is driven |
| wideSys | input | 1 | All devices are 16-bit; consider and check the upper byte |
| parityEn | input | 1 | Enable parity checking |
| acceptStb | output | 1 | One-cycle pulse: selection accepted |
| initiatorId | output | 4 | Binary initiator ID, valid while `acceptStb` is high |
| parityErr | output | 1 | One-cycle pulse: a checked byte failed parity |

## Verification
All three outputs come from one register stage. The bench drives an event on a falling edge and takes the accept, ID and parity-error results at the next falling edge, one rising edge later. It drops `selValid` at that same edge and samples again one cycle later to confirm that all outputs have returned to zero. Stimulus and sampling stay on falling edges throughout, so each comparison sees exactly one rising edge after its stimulus.

// File: rtl/sel_qualifier_pkg.sv
package sel_qualifier_pkg;

  // Strobes from the decision logic to the datapath output stage.
  typedef struct packed {
    logic accept;   // register an accepted selection
    logic parErr;   // register a parity error pulse
    logic pairSel;  // two lines asserted: report the other line's index
  } selStrobe_t;

endpackage

// File: rtl/sel_qualifier_datapath.sv
module sel_qualifier_datapath
  import sel_qualifier_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int LANE_W = 8,
  localparam int LANES = ID_W / LANE_W,
  localparam int IDX_W = $clog2(ID_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [ID_W-1:0]  idBus,
  input  logic [LANES-1:0] idPar,
  input  logic [IDX_W-1:0] localId,
  input  logic             wideSys,
  input  selStrobe_t       strobe,
  output logic             localHit,
  output logic [CNT_W-1:0] bitCount,
  output logic [LANES-1:0] laneBad,
  output logic             acceptStb,
  output logic [IDX_W-1:0] initiatorId,
  output logic             parityErr
);

  logic [ID_W-1:0]  visible;
  logic [IDX_W-1:0] otherIdx;

  // Lane 0 is always visible; upper lanes only in a wide system.
  for (genvar l = 0; l < LANES; l++) begin : gLane
    logic laneOn;
    assign laneOn = (l == 0) || wideSys;
    assign visible[l*LANE_W +: LANE_W] = laneOn ? idBus[l*LANE_W +: LANE_W] : '0;
    // Odd parity: XOR of data and parity must be 1.
    assign laneBad[l] = ~(^{idBus[l*LANE_W +: LANE_W], idPar[l]});
  end

  assign localHit = visible[localId];

  always_comb begin
    bitCount = '0;
    otherIdx = '0;
    for (int i = 0; i < ID_W; i++) begin
      bitCount = bitCount + CNT_W'(visible[i]);
      if (visible[i] && (IDX_W'(i) != localId)) otherIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acceptStb   <= 1'b0;
      parityErr   <= 1'b0;
      initiatorId <= '0;
    end else begin
      acceptStb   <= strobe.accept;
      parityErr   <= strobe.parErr;
      initiatorId <= (strobe.accept && strobe.pairSel) ? otherIdx : '0;
    end
  end

endmodule

// File: rtl/sel_qualifier_control.sv
module sel_qualifier_control
  import sel_qualifier_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int LANE_W = 8,
  localparam int LANES = ID_W / LANE_W,
  localparam int IDX_W = $clog2(ID_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             selValid,
  input  logic             disSingleInit,
  input  logic             wideSys,
  input  logic             parityEn,
  input  logic             localHit,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [LANES-1:0] laneBad,
  output selStrobe_t       strobe
);

  logic [LANES-1:0] laneChk;
  logic parFail, pair, single, idOk;

  for (genvar l = 0; l < LANES; l++) begin : gChk
    assign laneChk[l] = parityEn && ((l == 0) || wideSys);
  end

  assign parFail = |(laneBad & laneChk);
  assign pair    = (bitCount == CNT_W'(2));
  assign single  = (bitCount == CNT_W'(1));
  assign idOk    = localHit && (pair || (single && !disSingleInit));

  always_comb begin
    strobe.accept  = selValid && idOk && !parFail;
    strobe.parErr  = selValid && parFail;
    strobe.pairSel = pair;
  end

endmodule

// File: rtl/sel_qualifier.sv
module sel_qualifier
  import sel_qualifier_pkg::*;
#(
  parameter int ID_W   = 16,
  parameter int LANE_W = 8,
  localparam int LANES = ID_W / LANE_W,
  localparam int IDX_W = $clog2(ID_W),
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selValid,
  input  logic [ID_W-1:0]  idBus,
  input  logic [LANES-1:0] idPar,
  input  logic [IDX_W-1:0] localId,
  input  logic             disSingleInit,
  input  logic             wideSys,
  input  logic             parityEn,
  output logic             acceptStb,
  output logic [IDX_W-1:0] initiatorId,
  output logic             parityErr
);

  selStrobe_t       strobe;
  logic             localHit;
  logic [CNT_W-1:0] bitCount;
  logic [LANES-1:0] laneBad;

  sel_qualifier_control #(.ID_W(ID_W), .LANE_W(LANE_W)) u_ctl (
    .selValid(selValid), .disSingleInit(disSingleInit), .wideSys(wideSys),
    .parityEn(parityEn), .localHit(localHit), .bitCount(bitCount),
    .laneBad(laneBad), .strobe(strobe)
  );

  sel_qualifier_datapath #(.ID_W(ID_W), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rstN(rstN), .idBus(idBus), .idPar(idPar), .localId(localId),
    .wideSys(wideSys), .strobe(strobe), .localHit(localHit),
    .bitCount(bitCount), .laneBad(laneBad), .acceptStb(acceptStb),
    .initiatorId(initiatorId), .parityErr(parityErr)
  );

endmodule

// File: rtl/sel_qualifier_chk.sv
module sel_qualifier_chk #(
  parameter int ID_W   = 16,
  parameter int LANE_W = 8,
  localparam int LANES = ID_W / LANE_W,
  localparam int IDX_W = $clog2(ID_W)
) (
  input logic             clk,
  input logic             rstN,
  input logic             selValid,
  input logic [ID_W-1:0]  idBus,
  input logic [LANES-1:0] idPar,
  input logic [IDX_W-1:0] localId,
  input logic             disSingleInit,
  input logic             wideSys,
  input logic             parityEn,
  input logic             acceptStb,
  input logic [IDX_W-1:0] initiatorId,
  input logic             parityErr
);

  // Inputs as seen at the previous edge (the sampling edge).
  logic [ID_W-1:0]  prevVis;
  logic [IDX_W-1:0] prevLid;
  logic [LANES-1:0] prevPar;
  logic             prevDsi, prevPe, prevSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevVis <= '0; prevLid <= '0; prevPar <= '0;
      prevDsi <= 1'b0; prevPe <= 1'b0; prevSel <= 1'b0;
    end else begin
      prevVis <= wideSys ? idBus : {{(ID_W-LANE_W){1'b0}}, idBus[LANE_W-1:0]};
      prevLid <= localId; prevPar <= idPar;
      prevDsi <= disSingleInit; prevPe <= parityEn; prevSel <= selValid;
    end
  end

  // R10
  no_accept_on_parerr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptStb && parityErr));

  // R2
  accept_needs_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStb || parityErr) |-> prevSel);

  // R4
  local_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |-> prevVis[prevLid]);

  // R7
  line_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    acceptStb |-> ($countones(prevVis) == 1 || $countones(prevVis) == 2));

  // R6
  single_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (acceptStb && prevDsi) |-> ($countones(prevVis) == 2));

  // R8
  parity_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !prevPe |-> !parityErr);

  // R5
  id_zero_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !acceptStb |-> (initiatorId == '0));

  logic unusedPar;
  assign unusedPar = ^prevPar;

endmodule

bind sel_qualifier sel_qualifier_chk #(.ID_W(ID_W), .LANE_W(LANE_W)) u_chk (
  .clk(clk), .rstN(rstN), .selValid(selValid), .idBus(idBus), .idPar(idPar),
  .localId(localId), .disSingleInit(disSingleInit), .wideSys(wideSys),
  .parityEn(parityEn), .acceptStb(acceptStb), .initiatorId(initiatorId),
  .parityErr(parityErr)
);

// File: tb/sel_qualifier_bench.sv
module sel_qualifier_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        selValid = 1'b0;
  logic [15:0] idBus = '0;
  logic [1:0]  idPar = '0;
  logic [3:0]  localId = '0;
  logic        disSingleInit = 1'b0, wideSys = 1'b0, parityEn = 1'b0;
  logic        acceptStb, parityErr;
  logic [3:0]  initiatorId;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sel_qualifier u_sel_qualifier (
    .clk(clk), .rstN(rstN), .selValid(selValid), .idBus(idBus), .idPar(idPar),
    .localId(localId), .disSingleInit(disSingleInit), .wideSys(wideSys),
    .parityEn(parityEn), .acceptStb(acceptStb), .initiatorId(initiatorId),
    .parityErr(parityErr)
  );

  task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {acc,perr,id} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Run one selection event and compare against the requirement model.
  task automatic runEvent(bit dsi, bit wide, bit pe, logic [3:0] lid,
                          logic [15:0] bus, logic [1:0] par, bit parFlipped);
    logic [15:0] vis;
    int cnt;
    int other;
    bit hit, loBad, hiBad, perr, acc;
    logic [3:0] expId;
    string tag;
    vis = wide ? bus : {8'h00, bus[7:0]};
    cnt = 0; other = 0;
    for (int i = 0; i < 16; i++) begin
      if (vis[i]) begin
        cnt++;
        if (i != int'(lid)) other = i;
      end
    end
    hit   = vis[lid];
    loBad = pe && (((^bus[7:0]) ^ par[0]) == 1'b0);
    hiBad = pe && wide && (((^bus[15:8]) ^ par[1]) == 1'b0);
    perr  = loBad || hiBad;
    acc   = !perr && hit && (cnt == 2 || (cnt == 1 && !dsi));
    expId = (acc && cnt == 2) ? 4'(other) : 4'd0;
    if (!pe && parFlipped)       tag = "R8";
    else if (hiBad && !loBad)    tag = "R9";
    else if (perr)               tag = "R10";
    else if (cnt == 0 || cnt > 2) tag = "R7";
    else if (!hit)               tag = "R4";
    else if (cnt == 1)           tag = "R6";
    else if (!wide && bus[15:8] != 0) tag = "R3";
    else                         tag = "R5";

    @(negedge clk);
    disSingleInit = dsi; wideSys = wide; parityEn = pe;
    localId = lid; idBus = bus; idPar = par; selValid = 1'b1;
    @(negedge clk);
    check(tag, {acceptStb, parityErr, initiatorId}, {acc, perr, expId});
    selValid = 1'b0;
    @(negedge clk);
    check("R2", {acceptStb, parityErr, initiatorId}, 6'b0);
  endtask

  function automatic logic [1:0] goodPar(logic [15:0] bus);
    return {~^bus[15:8], ~^bus[7:0]};
  endfunction

  initial begin
    logic [3:0] lids [4];
    lids = '{4'd0, 4'd5, 4'd9, 4'd15};
    repeat (3) @(negedge clk);
    // R1: outputs cleared in reset
    check("R1", {acceptStb, parityErr, initiatorId}, 6'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {acceptStb, parityErr, initiatorId}, 6'b0);

    for (int li = 0; li < 4; li++)
      for (int mode = 0; mode < 8; mode++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++)
            for (int pv = 0; pv < 4; pv++) begin
              logic [15:0] bus;
              logic [1:0] par;
              bus = (16'd1 << i) | (16'd1 << j);
              par = goodPar(bus);
              if (pv == 1) par[0] = ~par[0];
              if (pv == 2) par[1] = ~par[1];
              if (pv == 3) par[1] = 1'b0;  // narrow initiator leaves it low
              runEvent(mode[2], mode[1], mode[0], lids[li], bus, par, pv != 0);
            end

    // R7: no lines and three lines asserted
    for (int mode = 0; mode < 8; mode++)
      for (int i = 0; i < 16; i++) begin
        logic [15:0] bus;
        bus = (16'd1 << i) | (16'd1 << ((i + 1) % 16)) | (16'd1 << 5);
        runEvent(mode[2], mode[1], mode[0], 4'd5, bus, goodPar(bus), 1'b0);
        runEvent(mode[2], mode[1], mode[0], 4'(i), 16'h0000, goodPar(16'h0000), 1'b0);
      end

    done = 1'b1;
  end

  initial begin
    while (!done && cycles < 190000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule